// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is a 12-bit down-counter. It advances on one of four tick rates. Three of the rates are cut from a 4096 Hz base strobe, and the fourth is an external once-per-minute strobe. Software loads the count through a low byte and an upper nibble, picks a rate with a two-bit select, and arms the timer with a run-enable bit. Each tick takes one from the count.

When a tick moves the count from one to zero, the timer stops by itself and raises a sticky expiry flag. If the interrupt enable is set at that moment, it also emits a one-cycle interrupt pulse. The flag holds until software clears it.

Register decoding and the bus sit outside the block. The surrounding register file presents per-minute (select 10) after reset. The block's own copy of the select also resets to that value, so that select coming out of reset does not count as a rate change.

Top module: `cdtmr_top`

## Requirements
- R1: After reset the count reads 0x000, the flag and the interrupt are low, and the timer is stopped.
- R2: A low-byte write loads count bits 7:0. A high write loads count bits 11:8 from write-data bits 3:0. The high readback byte carries the count bits 11:8 in its bits 3:0 and reads 0 in bits 7:4. A write in the same cycle as a tick wins, and later ticks decrement the written value.
- R3: Select 11 takes a tick from every base strobe. Select 00 takes one from every 64th base strobe. Select 01 takes one from every 4096th base strobe. Select 10 takes one from every minute strobe and ignores base strobes.
- R4: The timer starts on a rising edge of the run enable. The count changes only while the timer runs, and a low run enable stops it and holds the count.
- R5: A tick at count 1 gives count 0 and stops the timer. Further ticks leave the count at 0 until the run enable rises again.
- R6: A tick while the timer runs at count 0 wraps the count to 0xFFF and does not set the flag.
- R7: Expiry sets the flag. The flag stays set until a clear request, and an expiry in the same cycle as a clear leaves it set.
- R8: On expiry the interrupt output is high for exactly one cycle, the same cycle the flag first reads set, and only when the interrupt enable is high.
- R9: The base-strobe prescaler restarts from zero whenever the select changes or the timer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_stb_i | input | 1 | One-cycle 4096 Hz base strobe |
| min_stb_i | input | 1 | One-cycle minute strobe |
| rate_sel_i | input | 2 | Tick rate select (00 64 Hz, 01 1 Hz, 10 per minute, 11 4096 Hz) |
| run_en_i | input | 1 | Run enable, start on rising edge |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_lo_we_i | input | 1 | Low count byte write strobe |
| cnt_hi_we_i | input | 1 | High count nibble write strobe |
| cnt_wdata_i | input | 8 | Count write data |
| flag_clr_i | input | 1 | Expiry flag clear request |
| cnt_lo_o | output | 8 | Count bits 7:0 |
| cnt_hi_o | output | 8 | Count bits 11:8 in bits 3:0, zero above |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | One-cycle expiry interrupt |

## Verification
The hardest case to reach from the ports is a prescaler restart in the middle of a division. A restart leaves no trace of its own, and shows only as a tick arriving later than it would have. The stimulus first advances the prescaler partway, by 40 base strobes in 64 Hz mode, with the timer either stopped or running. It then starts the timer, or toggles the select away and back. After that it shows that 30 further strobes give no tick where an uncleared prescaler would have given one. The per-second rate is reached by pulsing the base strobe every other clock, so two seconds' worth of ticks fits in about sixteen thousand cycles.

// File: rtl/cdtmr_pkg.sv
package cdtmr_pkg;
  typedef enum logic [1:0] {
    RATE_DIV64  = 2'b00,
    RATE_DIV4K  = 2'b01,
    RATE_MINUTE = 2'b10,
    RATE_BASE   = 2'b11
  } rate_e;
endpackage

// File: rtl/cdtmr_prescale.sv
module cdtmr_prescale
  import cdtmr_pkg::*;
#(
  parameter int DIV_FAST = 64,
  parameter int DIV_SLOW = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_stb_i,
  input  logic       min_stb_i,
  input  logic [1:0] rate_sel_i,
  input  logic       start_i,
  output logic       tick_o
);
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);

  rate_e            sel_q, sel_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             clr;
  logic [PRE_W-1:0] lim;
  logic             tick_raw;

  always_comb begin
    sel_d = rate_e'(rate_sel_i);
    clr   = start_i | (sel_d != sel_q);
    lim   = (sel_d == RATE_DIV64) ? LIM_FAST : LIM_SLOW;
    pre_d = pre_q;
    if (clr) begin
      pre_d = '0;
    end else if (base_stb_i) begin
      pre_d = (pre_q == lim) ? '0 : pre_q + PRE_W'(1);
    end
    unique case (sel_d)
      RATE_BASE:   tick_raw = base_stb_i;
      RATE_DIV64:  tick_raw = base_stb_i & (pre_q == LIM_FAST);
      RATE_DIV4K:  tick_raw = base_stb_i & (pre_q == LIM_SLOW);
      RATE_MINUTE: tick_raw = min_stb_i;
      default:     tick_raw = 1'b0;
    endcase
    tick_o = tick_raw & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RATE_MINUTE;
      pre_q <= '0;
    end else begin
      sel_q <= sel_d;
      pre_q <= pre_d;
    end
  end

  // R9: any select change or start leaves the prescaler at zero
  p_pre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || (rate_sel_i != sel_q)) |=> (pre_q == '0));

  // R3: in 64 Hz mode a tick only on the strobe that closes a division
  p_fast_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && rate_sel_i == 2'b00) |=> (pre_q == '0));
endmodule

// File: rtl/cdtmr_count.sv
module cdtmr_count #(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en_i,
  input  logic              tick_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              start_o,
  output logic              expire_o
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             en_q;
  logic             wr;
  logic             step;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^wdata_i[BYTE_W-1:HI_W];

  always_comb begin
    wr       = lo_we_i | hi_we_i;
    start_o  = run_en_i & ~en_q;
    step     = run_q & tick_i & ~wr;
    expire_o = step & (cnt_q == CNT_W'(1));
    cnt_d    = cnt_q;
    if (wr) begin
      if (lo_we_i) cnt_d[BYTE_W-1:0]     = wdata_i;
      if (hi_we_i) cnt_d[CNT_W-1:BYTE_W] = wdata_i[HI_W-1:0];
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    run_d = run_q;
    if (!run_en_i)    run_d = 1'b0;
    else if (start_o) run_d = 1'b1;
    else if (expire_o) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      en_q  <= run_en_i;
    end
  end

  assign cnt_o = cnt_q;

  // R2: a low-byte write lands even when a tick coincides
  p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we_i |=> (cnt_q[BYTE_W-1:0] == $past(wdata_i)));

  // R4: a stopped timer holds its count
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr) |=> (cnt_q == $past(cnt_q)));

  // R4: a rising run enable arms the timer
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_i && !en_q) |=> run_q);

  // R5: reaching zero stops the timer
  p_stop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0 && !run_q));

  // R6: running tick at zero wraps to all ones
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0) |=> (cnt_q == '1));
endmodule

// File: rtl/cdtmr_flag_irq.sv
module cdtmr_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (expire_i)        flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    irq_d = expire_i & irq_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R7: the flag holds without a clear request
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q);

  // R8: interrupt lasts one cycle
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8: interrupt only alongside the flag, and only when enabled
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (flag_q && $past(irq_en_i)));
endmodule

// File: rtl/cdtmr_top.sv
module cdtmr_top #(
  parameter int CNT_W    = 12,
  parameter int BYTE_W   = 8,
  parameter int DIV_FAST = 64,
  parameter int DIV_SLOW = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_stb_i,
  input  logic              min_stb_i,
  input  logic [1:0]        rate_sel_i,
  input  logic              run_en_i,
  input  logic              irq_en_i,
  input  logic              cnt_lo_we_i,
  input  logic              cnt_hi_we_i,
  input  logic [BYTE_W-1:0] cnt_wdata_i,
  input  logic              flag_clr_i,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             tick;
  logic             start;
  logic             expire;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  cdtmr_prescale #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_pre (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .base_stb_i (base_stb_i),
    .min_stb_i  (min_stb_i),
    .rate_sel_i (rate_sel_i),
    .start_i    (start),
    .tick_o     (tick)
  );

  cdtmr_count #(
    .CNT_W  (CNT_W),
    .BYTE_W (BYTE_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run_en_i (run_en_i),
    .tick_i   (tick),
    .lo_we_i  (cnt_lo_we_i),
    .hi_we_i  (cnt_hi_we_i),
    .wdata_i  (cnt_wdata_i),
    .cnt_o    (cnt),
    .start_o  (start),
    .expire_o (expire)
  );

  cdtmr_flag_irq u_flag (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .expire_i   (expire),
    .irq_en_i   (irq_en_i),
    .flag_clr_i (flag_clr_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  assign cnt_lo_o = cnt[BYTE_W-1:0];
  assign cnt_hi_o = {{(2*BYTE_W-CNT_W){1'b0}}, cnt[CNT_W-1:BYTE_W]};

  // R1: nothing is flagged while reset is held
  always_comb begin
    if (!rst_s_n) begin
      a_reset_quiet_r1: assert (!flag_o && !irq_o && cnt == '0);
    end
  end

  // R2: the high readback byte carries only the upper count bits
  p_hi_readback_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_hi_we_i |=> (cnt_hi_o[HI_W-1:0] == $past(cnt_wdata_i[HI_W-1:0])));
endmodule

// File: tb/cdtmr_top_tb_top.sv
module cdtmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_stb = 1'b0, min_stb = 1'b0;
  logic [1:0] sel = 2'b10;
  logic       run_en = 1'b0, irq_en = 1'b0;
  logic       lo_we = 1'b0, hi_we = 1'b0, flag_clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] cnt_lo, cnt_hi;
  logic       flag, irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cdtmr_top dut_i (
    .clk (clk), .rst_n (rst_n), .base_stb_i (base_stb), .min_stb_i (min_stb),
    .rate_sel_i (sel), .run_en_i (run_en), .irq_en_i (irq_en),
    .cnt_lo_we_i (lo_we), .cnt_hi_we_i (hi_we), .cnt_wdata_i (wdata),
    .flag_clr_i (flag_clr), .cnt_lo_o (cnt_lo), .cnt_hi_o (cnt_hi),
    .flag_o (flag), .irq_o (irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  typedef struct packed {
    logic [1:0]  sel;
    logic        ie;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [15:0] nbase;
    logic [3:0]  nmin;
    logic [11:0] ecnt;
    logic        eflag;
    logic [3:0]  eirq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'b11, 1'b1, 8'h05, 8'h00, 16'd3,    4'd0, 12'h002, 1'b0, 4'd0},
    '{2'b11, 1'b1, 8'h03, 8'h00, 16'd3,    4'd0, 12'h000, 1'b1, 4'd1},
    '{2'b11, 1'b1, 8'h03, 8'h00, 16'd6,    4'd0, 12'h000, 1'b1, 4'd1},
    '{2'b00, 1'b1, 8'h04, 8'h00, 16'd130,  4'd0, 12'h002, 1'b0, 4'd0},
    '{2'b00, 1'b0, 8'h02, 8'h00, 16'd128,  4'd0, 12'h000, 1'b1, 4'd0},
    '{2'b10, 1'b1, 8'h02, 8'h00, 16'd500,  4'd1, 12'h001, 1'b0, 4'd0},
    '{2'b10, 1'b1, 8'h01, 8'h00, 16'd0,    4'd1, 12'h000, 1'b1, 4'd1},
    '{2'b01, 1'b1, 8'h03, 8'h00, 16'd8197, 4'd0, 12'h001, 1'b0, 4'd0},
    '{2'b11, 1'b1, 8'h23, 8'h01, 16'd35,   4'd0, 12'h100, 1'b0, 4'd0},
    '{2'b11, 1'b1, 8'h00, 8'hFF, 16'd1,    4'd0, 12'hEFF, 1'b0, 4'd0},
    '{2'b11, 1'b1, 8'h00, 8'h00, 16'd1,    4'd0, 12'hFFF, 1'b0, 4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int count_now();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_base();
    base_stb = 1'b1; cyc(); base_stb = 1'b0; cyc();
  endtask

  task automatic pulse_min();
    min_stb = 1'b1; cyc(); min_stb = 1'b0; cyc();
  endtask

  task automatic load(input logic [7:0] lo, input logic [7:0] hi);
    lo_we = 1'b1; wdata = lo; cyc(); lo_we = 1'b0;
    hi_we = 1'b1; wdata = hi; cyc(); hi_we = 1'b0;
  endtask

  task automatic prep(input logic [1:0] s, input logic ie);
    run_en = 1'b0; sel = s; irq_en = ie; flag_clr = 1'b1; cyc();
    flag_clr = 1'b0; cyc();
  endtask

  task automatic start();
    run_en = 1'b1; irq_seen = 0; cyc(); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R1: outputs under reset
    chk("R1 count in reset", count_now(), 0);
    chk("R1 flag in reset", flag, 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 count after reset", count_now(), 0);
    chk("R1 flag/irq after reset", {flag, irq}, 0);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      prep(v.sel, v.ie);
      load(v.lo, v.hi);
      start();
      for (int k = 0; k < int'(v.nbase); k++) pulse_base();
      for (int k = 0; k < int'(v.nmin); k++) pulse_min();
      cyc();
      chk($sformatf("R3/R5/R6 vec%0d count", i), count_now(), int'(v.ecnt));
      chk($sformatf("R7 vec%0d flag", i), flag, int'(v.eflag));
      chk($sformatf("R8 vec%0d irq pulses", i), irq_seen, int'(v.eirq));
    end

    // R7: flag sticks, then clears on request
    prep(2'b11, 1'b1);
    load(8'h01, 8'h00);
    start();
    pulse_base();
    repeat (5) cyc();
    chk("R7 flag sticky", flag, 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0; cyc();
    chk("R7 flag cleared", flag, 0);

    // R7: expiry coinciding with clear keeps flag set
    prep(2'b11, 1'b1);
    load(8'h01, 8'h00);
    start();
    base_stb = 1'b1; flag_clr = 1'b1; cyc();
    base_stb = 1'b0; flag_clr = 1'b0; cyc();
    chk("R7 set beats clear", flag, 1);

    // R5: after expiry with run enable held, a reload does not count
    load(8'h03, 8'h00);
    pulse_base();
    chk("R5 stopped after expiry", count_now(), 3);
    run_en = 1'b0; cyc();
    start();
    pulse_base();
    chk("R5 restart on new rising edge", count_now(), 2);

    // R2: write while running, and write beats a same-cycle tick
    prep(2'b11, 1'b1);
    load(8'h0A, 8'h00);
    start();
    pulse_base(); pulse_base();
    chk("R2 running count", count_now(), 8);
    lo_we = 1'b1; wdata = 8'd20; base_stb = 1'b1; cyc();
    lo_we = 1'b0; base_stb = 1'b0; cyc();
    chk("R2 write beats tick", count_now(), 20);
    pulse_base();
    chk("R2 next tick from written value", count_now(), 19);

    // R4: dropping run enable holds the count
    run_en = 1'b0; cyc();
    pulse_base(); pulse_base(); pulse_base();
    chk("R4 hold while stopped", count_now(), 19);

    // R9: start clears a partly advanced prescaler
    prep(2'b00, 1'b1);
    load(8'h05, 8'h00);
    for (int k = 0; k < 40; k++) pulse_base();
    start();
    for (int k = 0; k < 30; k++) pulse_base();
    chk("R9 start clears prescaler", count_now(), 5);
    for (int k = 0; k < 34; k++) pulse_base();
    chk("R9 tick after full division", count_now(), 4);

    // R9: select change clears the prescaler
    for (int k = 0; k < 40; k++) pulse_base();
    sel = 2'b01; cyc(); sel = 2'b00; cyc();
    for (int k = 0; k < 30; k++) pulse_base();
    chk("R9 select change clears prescaler", count_now(), 4);
    for (int k = 0; k < 34; k++) pulse_base();
    chk("R9 tick after select change", count_now(), 3);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule